// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches a set of external event lines, already synchronous to its clock, and turns selected signal edges into sticky pending flags. For each line, software chooses whether a rising edge, a falling edge, both or neither should count as an event. A detected event latches the line's pending flag. Each line has its own interrupt output, which is high while the line is both pending and unmasked. A downstream priority controller consumes these outputs.

Software reaches five word registers through a simple single-cycle write port and a combinational read port. The word addresses are: 0 for the unmask register, 1 for rising-edge select, 2 for falling-edge select, 3 for pending, and 4 for software trigger. Pending flags are cleared by writing 1 to them. A write of 1 to the software-trigger register forces a line pending without any edge on the pin.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and every interrupt output is 0. A line held high or low through reset does not produce an event when reset is released.
- R2: When a line's bit in rising-select (address 1) is 1, a 0-to-1 change on that line sets its pending bit (address 3, bit = line index) at the first clock edge at which the new level is present.
- R3: When a line's bit in falling-select (address 2) is 1, a 1-to-0 change on that line sets its pending bit at the first clock edge at which the new level is present.
- R4: A line with both select bits set becomes pending on an edge in either direction.
- R5: An edge whose select bit is 0 leaves the pending bit unchanged.
- R6: A pending bit stays set until software writes 1 to it at address 3. Writing 0 to a pending bit has no effect.
- R7: If an enabled edge and a write-1 clear of the same pending bit fall in the same cycle, the bit ends set.
- R8: Writing 1 to a bit at address 4 sets that line's pending bit, whatever the edge selects are. That software-trigger bit reads 1 until the pending bit is cleared, and then it reads 0. Writing 0 at address 4 has no effect.
- R9: Interrupt output bit i equals pending bit i AND unmask bit i (address 0, 1 = enabled).
- R10: Register bits at or above NUM_LINES (23 by default) read 0 and ignore writes. Addresses 5 to 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | NUM_LINES | Event lines, synchronous to clk |
| bus_wen | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 3 | Word address for both read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the word at bus_addr, combinational |
| irq | output | NUM_LINES | Per-line interrupt request |

## Verification
The lines are first driven through reset at non-zero levels, which separates a previous-value register that is loaded on reset from one that is cleared on reset. Directed steps follow. They use lines that have only rising select, only falling select, both or neither, so each select path is shown to act alone and a swapped or ignored select stands out. The edge-versus-clear collision and the software-trigger one-shot are tried on their own. A long phase of pseudo-random line toggling, mixed with writes to every address including unmapped ones, is then compared against a behavioural model on every cycle.

// File: rtl/eirq_pkg.sv
// Package: shared register addresses and bus widths for the edge-triggered
// interrupt controller. Assumes a 3-bit word address space.
package eirq_pkg;
    localparam int REG_ADDR_W = 3;

    typedef enum logic [REG_ADDR_W-1:0] {
        SEL_UNMASK = 3'd0,
        SEL_RISE   = 3'd1,
        SEL_FALL   = 3'd2,
        SEL_PEND   = 3'd3,
        SEL_SWTRIG = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/eirq_edge_det.sv
// Edge detector: one previous-value flop per line. The previous value takes the
// live input during reset, so releasing reset never yields a false edge.
// Assumes line_in is already synchronous to clk.
module eirq_edge_det #(
    parameter int NUM_LINES = 23
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_in,
    output logic [NUM_LINES-1:0] rise_ev,
    output logic [NUM_LINES-1:0] fall_ev
);
    logic [NUM_LINES-1:0] prev_q;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        // Track last cycle's level of line i (reset loads the live level)
        always_ff @(posedge clk) begin
            prev_q[i] <= line_in[i];
        end
        // Compare live level against last cycle's level
        always_comb begin
            rise_ev[i] = line_in[i] & ~prev_q[i];
            fall_ev[i] = ~line_in[i] & prev_q[i];
        end
    end

    // R2
    rise_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rise_ev == (line_in & ~$past(line_in))));
    // R3
    fall_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (fall_ev == (~line_in & $past(line_in))));
endmodule

// File: rtl/eirq_cfg_regs.sv
// Configuration registers: unmask, rising-select and falling-select, each one
// bit per line. Write data beyond NUM_LINES is never presented here.
module eirq_cfg_regs
    import eirq_pkg::*;
#(
    parameter int NUM_LINES = 23
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wen,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [NUM_LINES-1:0]  wdata,
    output logic [NUM_LINES-1:0]  unmask_q,
    output logic [NUM_LINES-1:0]  rise_sel_q,
    output logic [NUM_LINES-1:0]  fall_sel_q
);
    // Load the addressed configuration word, clear all on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unmask_q   <= '0;
            rise_sel_q <= '0;
            fall_sel_q <= '0;
        end else if (wen) begin
            case (addr)
                SEL_UNMASK: unmask_q   <= wdata;
                SEL_RISE:   rise_sel_q <= wdata;
                SEL_FALL:   fall_sel_q <= wdata;
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/eirq_pend.sv
// Pending and software-trigger state. A set request (edge or software) wins
// over a write-1 clear in the same cycle. A software-trigger bit lives only as
// long as its pending bit does.
module eirq_pend #(
    parameter int NUM_LINES = 23
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] edge_set,
    input  logic [NUM_LINES-1:0] sw_set,
    input  logic [NUM_LINES-1:0] clr_req,
    output logic [NUM_LINES-1:0] pend_q,
    output logic [NUM_LINES-1:0] swtrig_q
);
    logic [NUM_LINES-1:0] set_vec;
    logic [NUM_LINES-1:0] pend_d;
    logic [NUM_LINES-1:0] swtrig_d;

    // Next pending and trigger state: set dominates clear
    always_comb begin
        set_vec  = edge_set | sw_set;
        pend_d   = (pend_q & ~clr_req) | set_vec;
        swtrig_d = (swtrig_q | sw_set) & pend_d;
    end

    // Register pending and trigger bits, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= '0;
            swtrig_q <= '0;
        end else begin
            pend_q   <= pend_d;
            swtrig_q <= swtrig_d;
        end
    end

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pend_q & $past(set_vec)) == $past(set_vec)));
    // R6
    clear_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((($past(pend_q) & ~pend_q) & ~$past(clr_req)) == '0));
    // R8
    swtrig_within_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((swtrig_q & ~pend_q) == '0));
endmodule

// File: rtl/edge_irq_ctrl.sv
// Edge-triggered external interrupt controller top. It decodes the register
// port, gates edges with the per-line selects, and drives irq as pending AND
// unmask. Assumes NUM_LINES < DATA_W and inputs synchronous to clk.
module edge_irq_ctrl
    import eirq_pkg::*;
#(
    parameter int NUM_LINES = 23,
    parameter int DATA_W    = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LINES-1:0]  line_in,
    input  logic                  bus_wen,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [NUM_LINES-1:0]  irq
);
    logic [NUM_LINES-1:0] wdata_lines;
    logic [NUM_LINES-1:0] unmask_q, rise_sel_q, fall_sel_q;
    logic [NUM_LINES-1:0] rise_ev, fall_ev;
    logic [NUM_LINES-1:0] edge_set, sw_set, clr_req;
    logic [NUM_LINES-1:0] pend_q, swtrig_q;
    logic [NUM_LINES-1:0] rd_lines;
    logic                 unused_wdata_hi;

    assign wdata_lines     = bus_wdata[NUM_LINES-1:0];
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_LINES];

    eirq_cfg_regs #(.NUM_LINES(NUM_LINES)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wen        (bus_wen),
        .addr       (bus_addr),
        .wdata      (wdata_lines),
        .unmask_q   (unmask_q),
        .rise_sel_q (rise_sel_q),
        .fall_sel_q (fall_sel_q)
    );

    eirq_edge_det #(.NUM_LINES(NUM_LINES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_in),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev)
    );

    // Qualify edges with selects, decode write-1 strobes for pending/trigger
    always_comb begin
        edge_set = (rise_ev & rise_sel_q) | (fall_ev & fall_sel_q);
        sw_set   = (bus_wen && bus_addr == SEL_SWTRIG) ? wdata_lines : '0;
        clr_req  = (bus_wen && bus_addr == SEL_PEND)   ? wdata_lines : '0;
    end

    eirq_pend #(.NUM_LINES(NUM_LINES)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_set (edge_set),
        .sw_set   (sw_set),
        .clr_req  (clr_req),
        .pend_q   (pend_q),
        .swtrig_q (swtrig_q)
    );

    // Select the addressed word and zero-extend it to the bus width
    always_comb begin
        case (bus_addr)
            SEL_UNMASK: rd_lines = unmask_q;
            SEL_RISE:   rd_lines = rise_sel_q;
            SEL_FALL:   rd_lines = fall_sel_q;
            SEL_PEND:   rd_lines = pend_q;
            SEL_SWTRIG: rd_lines = swtrig_q;
            default:    rd_lines = '0;
        endcase
        bus_rdata = '0;
        bus_rdata[NUM_LINES-1:0] = rd_lines;
    end

    // Request per line: pending and unmasked
    assign irq = pend_q & unmask_q;

    // R9
    irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(irq == '0) && (irq != '0) |->
            ((irq & ~($past(edge_set | sw_set) | ($past(pend_q) & unmask_q))) == '0));
endmodule

// File: tb/edge_irq_ctrl_tb.sv
`timescale 1ns/1ps
module edge_irq_ctrl_tb;
    localparam int N  = 23;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  line_in = '0;
    logic          bus_wen = 1'b0;
    logic [2:0]    bus_addr = 3'd0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [N-1:0]  irq;

    int    vectors = 0;
    int    fails = 0;
    bit    live = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural reference state
    bit m_unmask[N], m_rise[N], m_fall[N], m_pend[N], m_swt[N], m_prev[N];

    always #2.5 clk = ~clk;

    edge_irq_ctrl #(.NUM_LINES(N), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .bus_wen(bus_wen),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [DW-1:0] pack(input bit a[N]);
        logic [DW-1:0] v = '0;
        for (int i = 0; i < N; i++) v[i] = a[i];
        return v;
    endfunction

    function automatic logic [DW-1:0] model_rd(input logic [2:0] a);
        case (a)
            3'd0: return pack(m_unmask);
            3'd1: return pack(m_rise);
            3'd2: return pack(m_fall);
            3'd3: return pack(m_pend);
            3'd4: return pack(m_swt);
            default: return '0;
        endcase
    endfunction

    function automatic logic [N-1:0] model_irq();
        logic [N-1:0] v = '0;
        for (int i = 0; i < N; i++) v[i] = m_pend[i] && m_unmask[i];
        return v;
    endfunction

    // reference model step on each clock
    always @(posedge clk) begin
        live = 1;
        for (int i = 0; i < N; i++) begin
            if (!rst_n) begin
                m_unmask[i] = 0; m_rise[i] = 0; m_fall[i] = 0;
                m_pend[i] = 0; m_swt[i] = 0;
            end else begin
                bit up, dn, ev, sw, cl, np;
                up = line_in[i] && !m_prev[i];
                dn = !line_in[i] && m_prev[i];
                ev = (up && m_rise[i]) || (dn && m_fall[i]);
                sw = bus_wen && bus_addr == 3'd4 && bus_wdata[i];
                cl = bus_wen && bus_addr == 3'd3 && bus_wdata[i];
                np = (ev || sw) ? 1'b1 : (cl ? 1'b0 : m_pend[i]);
                m_swt[i]  = (m_swt[i] || sw) && np;
                m_pend[i] = np;
                if (bus_wen && bus_addr == 3'd0) m_unmask[i] = bus_wdata[i];
                if (bus_wen && bus_addr == 3'd1) m_rise[i]   = bus_wdata[i];
                if (bus_wen && bus_addr == 3'd2) m_fall[i]   = bus_wdata[i];
            end
            m_prev[i] = line_in[i];
        end
    end

    // compare with the model once per cycle, away from the edge
    always @(negedge clk) begin
        #1;
        if (live && !done) begin
            vectors++;
            if (bus_rdata !== model_rd(bus_addr) || irq !== model_irq()) begin
                fails++;
                $display("FAIL %s: addr=%0d rdata=%h irq=%h expected rdata=%h irq=%h",
                         cur_req, bus_addr, bus_rdata, irq, model_rd(bus_addr), model_irq());
            end
        end
    end

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rdchk(input string tag, input logic [2:0] a, input logic [DW-1:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic set_lines(input logic [N-1:0] v);
        @(negedge clk);
        line_in = v;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr = 32'hACE1_2345;
        // R1: lines move during reset, then stay high on release
        line_in = 23'h0F0F0F;
        repeat (2) @(negedge clk);
        line_in = 23'h000F0F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        rdchk("R1", 3'd3, 32'h0);
        rdchk("R1", 3'd0, 32'h0);
        rdchk("R1", 3'd4, 32'h0);
        check("R1", {9'd0, irq}, 32'h0);

        // R10: write beyond implemented bits
        cur_req = "R10";
        wr(3'd0, 32'hFFFF_FFFF);
        rdchk("R10", 3'd0, 32'h007F_FFFF);
        wr(3'd5, 32'hFFFF_FFFF);
        rdchk("R10", 3'd5, 32'h0);
        rdchk("R10", 3'd7, 32'h0);

        // selects: rise on 0..7, fall on 4..11
        cur_req = "R2";
        wr(3'd1, 32'h0000_00FF);
        wr(3'd2, 32'h0000_0FF0);
        cur_req = "R3";
        set_lines(23'h000000);
        rdchk("R3", 3'd3, 32'h0000_0F00);
        cur_req = "R2";
        set_lines(23'h0000FF);
        rdchk("R2", 3'd3, 32'h0000_0FFF);
        wr(3'd3, 32'h0000_0FFF);
        rdchk("R6", 3'd3, 32'h0);
        cur_req = "R4";
        set_lines(23'h000000);
        rdchk("R4", 3'd3, 32'h0000_00F0);
        cur_req = "R5";
        set_lines(23'h700000);
        rdchk("R5", 3'd3, 32'h0000_00F0);

        // R6: partial clear and zero write
        cur_req = "R6";
        wr(3'd3, 32'h0000_0030);
        rdchk("R6", 3'd3, 32'h0000_00C0);
        wr(3'd3, 32'h0);
        rdchk("R6", 3'd3, 32'h0000_00C0);

        // R9: mask gating
        cur_req = "R9";
        wr(3'd0, 32'h0000_0080);
        @(negedge clk); #1;
        check("R9", {9'd0, irq}, 32'h0000_0080);

        // R7: edge and clear in the same cycle
        cur_req = "R7";
        wr(3'd3, 32'h007F_FFFF);
        @(negedge clk);
        line_in = 23'h700001;
        bus_wen = 1'b1; bus_addr = 3'd3; bus_wdata = 32'h0000_0001;
        @(negedge clk);
        bus_wen = 1'b0;
        rdchk("R7", 3'd3, 32'h0000_0001);

        // R8: software trigger one-shot on line 22
        cur_req = "R8";
        wr(3'd4, 32'h0040_0000);
        rdchk("R8", 3'd3, 32'h0040_0001);
        rdchk("R8", 3'd4, 32'h0040_0000);
        check("R9", {9'd0, irq}, 32'h0);
        wr(3'd0, 32'h0040_0000);
        @(negedge clk); #1;
        check("R9", {9'd0, irq}, 32'h0040_0000);
        wr(3'd4, 32'h0);
        rdchk("R8", 3'd4, 32'h0040_0000);
        wr(3'd3, 32'h0040_0000);
        rdchk("R8", 3'd4, 32'h0);
        rdchk("R8", 3'd3, 32'h0000_0001);

        // mixed traffic against the model
        cur_req = "mixed traffic";
        wr(3'd0, 32'h0055_AA33);
        wr(3'd1, 32'h0033_0F0F);
        wr(3'd2, 32'h0060_FF00);
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            line_in  = line_in ^ (lfsr[N-1:0] & lfsr[N+8:9]);
            bus_wen  = (lfsr[27:26] == 2'b00);
            bus_addr = lfsr[30:28];
            bus_wdata = {lfsr[7:0], lfsr[31:8]} & {lfsr[15:0], lfsr[31:16]};
        end
        @(negedge clk);
        bus_wen = 1'b0;
        repeat (2) @(negedge clk);

        done = 1;
        summary();
        $finish;
    end
endmodule